// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds two numbers held in a compact floating-point format: one sign bit, an 8-bit exponent biased by 127, and 10 stored fraction bits behind an implicit leading one. The work is split across four register-bounded steps: an exponent comparison by subtraction, a right shift that lines up the smaller operand, a magnitude add or subtract, and a normalizing shift with exponent correction. A fresh operand pair may enter on every clock, and results leave at the same rate once the pipeline has filled.

Operands are qualified by a valid strobe, and the result carries its own valid strobe. Rounding is by truncation. Special encodings (infinities, not-a-number, subnormals) and exception flags are not recognised: every exponent code, including zero, is read as a normal number with the hidden one present, and exponent arithmetic wraps.

Top module: `fpadd_pipe`

## Requirements
- R1: An operand or result word is laid out with the sign in bit 18, the biased exponent (bias 127) in bits 17..10 and the stored fraction in bits 9..0. Its value is (-1)^sign * 1.fraction * 2^(exponent-127) for every exponent code.
- R2: One operand pair is accepted on every cycle that in_valid is high. out_valid rises exactly 4 cycles later, one result per accepted pair, in order, with no gaps for back-to-back input.
- R3: The operand of larger magnitude (larger exponent, or equal exponents and larger fraction) is taken as the reference, regardless of which input port it arrived on.
- R4: The smaller operand's significand is shifted right by the exponent difference, with the shifted-out bits discarded; a difference greater than 10 makes its contribution zero.
- R5: When the signs agree, the aligned significands are added and the result keeps the common sign.
- R6: When the signs differ, the smaller aligned significand is subtracted from the larger, and the result takes the sign of the larger-magnitude operand.
- R7: If the significand sum carries past the hidden-one position, it is shifted right by one (low bit dropped) and the exponent rises by one.
- R8: If the significand result has leading zeros below the hidden-one position, it is shifted left by that count and the exponent falls by the same count.
- R9: A zero significand result produces the word 0 (positive zero).
- R10: The result exponent is taken modulo 256; a carry out of code 255 yields code 0, and a decrease below code 0 wraps upward.
- R11: While reset is applied and after its release until new input arrives, out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 19 | First operand |
| in_b | input | 19 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 19 | Sum of the operand pair accepted 4 cycles earlier |

## Verification
The main sweep streams every combination of exponent offsets from -14 to +14 around a mid-range exponent, four fractions per operand (zero, one, half-scale and all-ones) and all four sign pairs, back to back; this separates the alignment boundary at a difference of 10 from 11, the swap of operands by magnitude, the carry and cancellation normalizations, and exact cancellation to zero. A second sweep around a very small exponent makes cancellation drive the exponent below zero, and directed pairs at the top exponent code force the wrapping carry. Each result is also timed against its entry cycle, so a pipeline that drops, repeats or delays a beat is told apart from one that computes wrongly.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  // Kind of magnitude operation chosen from the operand signs
  typedef enum logic {
    MAG_ADD = 1'b0,
    MAG_SUB = 1'b1
  } mag_op_e;

endpackage

// File: rtl/fpadd_cmp.sv
// Step 1: exponent comparison by subtraction, reference operand selection
module fpadd_cmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [FW-1:0]    a_i,
  input  logic [FW-1:0]    b_i,
  output logic             v_o,
  output logic             big_sgn_o,
  output logic             sml_sgn_o,
  output logic [EXP_W-1:0] big_exp_o,
  output logic [EXP_W-1:0] dif_o,
  output logic [SIG_W-1:0] big_sig_o,
  output logic [SIG_W-1:0] sml_sig_o
);

  logic [EXP_W-1:0] exp_a, exp_b;
  logic [MAN_W-1:0] man_a, man_b;
  logic [EXP_W:0]   exp_sub, exp_neg;
  logic             a_ref;

  logic             big_sgn_d, sml_sgn_d;
  logic [EXP_W-1:0] big_exp_d, dif_d;
  logic [SIG_W-1:0] big_sig_d, sml_sig_d;

  assign exp_a = a_i[FW-2 -: EXP_W];
  assign exp_b = b_i[FW-2 -: EXP_W];
  assign man_a = a_i[MAN_W-1:0];
  assign man_b = b_i[MAN_W-1:0];

  always_comb begin
    exp_sub = {1'b0, exp_a} - {1'b0, exp_b};
    exp_neg = {(EXP_W+1){1'b0}} - exp_sub;
    // a is the reference when its exponent is larger, or equal with fraction not smaller
    a_ref = !exp_sub[EXP_W] && ((exp_sub != '0) || (man_a >= man_b));
    if (a_ref) begin
      big_sgn_d = a_i[FW-1];
      sml_sgn_d = b_i[FW-1];
      big_exp_d = exp_a;
      dif_d     = exp_sub[EXP_W-1:0];
      big_sig_d = {1'b1, man_a};
      sml_sig_d = {1'b1, man_b};
    end else begin
      big_sgn_d = b_i[FW-1];
      sml_sgn_d = a_i[FW-1];
      big_exp_d = exp_b;
      dif_d     = exp_neg[EXP_W-1:0];
      big_sig_d = {1'b1, man_b};
      sml_sig_d = {1'b1, man_a};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      big_sgn_o <= big_sgn_d;
      sml_sgn_o <= sml_sgn_d;
      big_exp_o <= big_exp_d;
      dif_o     <= dif_d;
      big_sig_o <= big_sig_d;
      sml_sig_o <= sml_sig_d;
    end
  end

  // R2: each accepted pair advances one step
  a_r2_cmp_advance: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> v_o);
  a_r2_cmp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> !v_o);
  // R3: the reference exponent is never below either input exponent
  a_r3_ref_exp: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (big_exp_o >= $past(exp_a)) && (big_exp_o >= $past(exp_b)));

endmodule

// File: rtl/fpadd_align.sv
// Step 2: right shift of the smaller significand by the exponent difference
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic             big_sgn_i,
  input  logic             sml_sgn_i,
  input  logic [EXP_W-1:0] big_exp_i,
  input  logic [EXP_W-1:0] dif_i,
  input  logic [SIG_W-1:0] big_sig_i,
  input  logic [SIG_W-1:0] sml_sig_i,
  output logic             v_o,
  output mag_op_e          op_o,
  output logic             sgn_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] big_sig_o,
  output logic [SIG_W-1:0] al_sig_o
);

  localparam logic [EXP_W-1:0] FAR_LIM = EXP_W'(MAN_W);

  logic [SIG_W-1:0] al_sig_d;
  mag_op_e          op_d;

  always_comb begin
    if (dif_i > FAR_LIM) al_sig_d = '0;
    else                 al_sig_d = sml_sig_i >> dif_i;
    op_d = (big_sgn_i != sml_sgn_i) ? MAG_SUB : MAG_ADD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      op_o      <= op_d;
      sgn_o     <= big_sgn_i;
      exp_o     <= big_exp_i;
      big_sig_o <= big_sig_i;
      al_sig_o  <= al_sig_d;
    end
  end

  // R4: a far operand contributes nothing
  a_r4_far_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && (dif_i > FAR_LIM)) |=> (al_sig_o == '0));
  // R4: alignment only ever discards bits
  a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (al_sig_o <= $past(sml_sig_i)));

endmodule

// File: rtl/fpadd_add.sv
// Step 3: magnitude add or subtract of the aligned significands
module fpadd_add
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  localparam int SIG_W = MAN_W + 1,
  localparam int SUM_W = MAN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  mag_op_e          op_i,
  input  logic             sgn_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] big_sig_i,
  input  logic [SIG_W-1:0] al_sig_i,
  output logic             v_o,
  output logic             sgn_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SUM_W-1:0] sum_o
);

  logic [SUM_W-1:0] sum_d;

  always_comb begin
    if (op_i == MAG_SUB) sum_d = {1'b0, big_sig_i} - {1'b0, al_sig_i};
    else                 sum_d = {1'b0, big_sig_i} + {1'b0, al_sig_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      sgn_o <= sgn_i;
      exp_o <= exp_i;
      sum_o <= sum_d;
    end
  end

  // R6: subtracting from the reference never borrows past it
  a_r6_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && (op_i == MAG_SUB)) |=> (sum_o <= {1'b0, $past(big_sig_i)}));
  // R5: an add never ends below the reference significand
  a_r5_add_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && (op_i == MAG_ADD)) |=> (sum_o >= {1'b0, $past(big_sig_i)}));

endmodule

// File: rtl/fpadd_norm.sv
// Step 4: normalization and exponent correction
module fpadd_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int SUM_W = MAN_W + 2,
  localparam int LZ_W  = $clog2(SUM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic             sgn_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic             v_o,
  output logic [FW-1:0]    res_o
);

  logic [LZ_W-1:0]  lz;
  logic [SIG_W-1:0] sig_n;
  logic [EXP_W-1:0] exp_n;
  logic [FW-1:0]    res_d;

  // leading zeros below the carry position; the highest set bit wins
  always_comb begin
    lz = '0;
    for (int i = 0; i < SIG_W; i++) begin
      if (sum_i[i]) lz = LZ_W'(MAN_W - i);
    end
  end

  always_comb begin
    sig_n = sum_i[SIG_W-1:0] << lz;
    exp_n = exp_i - EXP_W'(lz);
    if (sum_i[SUM_W-1]) begin
      sig_n = sum_i[SUM_W-1:1];
      exp_n = exp_i + EXP_W'(1);
    end
    if (sum_i == '0) res_d = '0;
    else             res_d = {sgn_i, exp_n, sig_n[MAN_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) res_o <= res_d;
  end

  // R9: exact cancellation gives positive zero
  a_r9_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && (sum_i == '0)) |=> (res_o == '0));
  // R7: a carry raises the exponent by one
  a_r7_carry_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && sum_i[SUM_W-1]) |=> (res_o[FW-2 -: EXP_W] == $past(exp_i) + EXP_W'(1)));
  // R8: without a carry the exponent never rises
  a_r8_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && !sum_i[SUM_W-1] && sum_i[SIG_W-1]) |=> (res_o[FW-2 -: EXP_W] == $past(exp_i)));

endmodule

// File: rtl/fpadd_pipe.sv
// Four-step floating-point adder, one operand pair per cycle
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  localparam int FW    = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int SUM_W = MAN_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_a,
  input  logic [FW-1:0] in_b,
  output logic          out_valid,
  output logic [FW-1:0] out_sum
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             c_v, c_bsg, c_ssg;
  logic [EXP_W-1:0] c_exp, c_dif;
  logic [SIG_W-1:0] c_bsig, c_ssig;

  logic             l_v, l_sgn;
  mag_op_e          l_op;
  logic [EXP_W-1:0] l_exp;
  logic [SIG_W-1:0] l_bsig, l_asig;

  logic             s_v, s_sgn;
  logic [EXP_W-1:0] s_exp;
  logic [SUM_W-1:0] s_sum;

  fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .v_i(in_valid), .a_i(in_a), .b_i(in_b),
    .v_o(c_v), .big_sgn_o(c_bsg), .sml_sgn_o(c_ssg), .big_exp_o(c_exp),
    .dif_o(c_dif), .big_sig_o(c_bsig), .sml_sig_o(c_ssig)
  );

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst_n(rst_int_n), .v_i(c_v), .big_sgn_i(c_bsg),
    .sml_sgn_i(c_ssg), .big_exp_i(c_exp), .dif_i(c_dif),
    .big_sig_i(c_bsig), .sml_sig_i(c_ssig), .v_o(l_v), .op_o(l_op),
    .sgn_o(l_sgn), .exp_o(l_exp), .big_sig_o(l_bsig), .al_sig_o(l_asig)
  );

  fpadd_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
    .clk(clk), .rst_n(rst_int_n), .v_i(l_v), .op_i(l_op), .sgn_i(l_sgn),
    .exp_i(l_exp), .big_sig_i(l_bsig), .al_sig_i(l_asig),
    .v_o(s_v), .sgn_o(s_sgn), .exp_o(s_exp), .sum_o(s_sum)
  );

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst_n(rst_int_n), .v_i(s_v), .sgn_i(s_sgn), .exp_i(s_exp),
    .sum_i(s_sum), .v_o(out_valid), .res_o(out_sum)
  );

  // R11: nothing leaves the pipe while reset is held
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> !out_valid);

endmodule

// File: tb/fpadd_pipe_tb.sv
`timescale 1ns/100ps
module fpadd_pipe_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [18:0] in_a, in_b;
  logic        out_valid;
  logic [18:0] out_sum;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [18:0] q_val [16];
  string       q_tag [16];
  int          q_cyc [16];
  int          wr = 0;
  int          rd = 0;

  always #2.5 clk = ~clk;

  fpadd_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // Arithmetic reference: value = 1.f * 2^(e-127), truncation, exponent mod 256
  function automatic logic [18:0] ref_sum(input logic [18:0] a, input logic [18:0] b,
                                          output string tag);
    int ea, eb, ma, mb, eg, es, mg, ms, d, al, s, e;
    bit sg, ss, swapped, far, carry, cancel;
    ea = int'(a[17:10]); eb = int'(b[17:10]);
    ma = 1024 + int'(a[9:0]); mb = 1024 + int'(b[9:0]);
    swapped = (ea < eb) || (ea == eb && ma < mb);
    if (swapped) begin eg = eb; mg = mb; sg = b[18]; es = ea; ms = ma; ss = a[18]; end
    else         begin eg = ea; mg = ma; sg = a[18]; es = eb; ms = mb; ss = b[18]; end
    d = eg - es;
    far = d > 10;
    al = far ? 0 : ms / (1 << d);
    s = (sg == ss) ? mg + al : mg - al;
    e = eg; carry = 0; cancel = 0;
    if (s == 0) begin
      tag = "R9";
      return 19'd0;
    end
    if (s >= 2048) begin s = s / 2; e = e + 1; carry = 1; end
    while (s < 1024) begin s = s * 2; e = e - 1; cancel = 1; end
    if (e > 255 || e < 0)   tag = "R10";
    else if (carry)         tag = "R7";
    else if (cancel)        tag = "R8";
    else if (far)           tag = "R4";
    else if (swapped)       tag = "R3";
    else if (sg != ss)      tag = "R6";
    else                    tag = "R5";
    return {sg, 8'(e & 255), 10'(s - 1024)};
  endfunction

  // one cycle: sample outputs at the falling edge, then drive new inputs
  task automatic step(input bit v, input logic [18:0] a, input logic [18:0] b,
                      input string force_tag);
    string t;
    logic [18:0] x;
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      checks++;
      if (rd == wr) begin
        errors++;
        $display("FAIL R2: result with nothing pending, got %h expected none", out_sum);
      end else begin
        if (out_sum !== q_val[rd % 16]) begin
          errors++;
          $display("FAIL %s: a+b got %h expected %h", q_tag[rd % 16], out_sum, q_val[rd % 16]);
        end
        checks++;
        if (cyc - q_cyc[rd % 16] != 4) begin
          errors++;
          $display("FAIL R2: latency got %0d expected 4", cyc - q_cyc[rd % 16]);
        end
        rd++;
      end
    end
    in_valid = v; in_a = a; in_b = b;
    if (v) begin
      x = ref_sum(a, b, t);
      q_val[wr % 16] = x;
      q_tag[wr % 16] = (force_tag != "") ? force_tag : t;
      q_cyc[wr % 16] = cyc;
      wr++;
    end
  endtask

  task automatic sweep(input int base);
    logic [9:0] fr [4] = '{10'h000, 10'h001, 10'h200, 10'h3FF};
    for (int de = -14; de <= 14; de++) begin
      if (base + de < 0 || base + de > 255) continue;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int s = 0; s < 4; s++)
            step(1'b1, {s[1], 8'(base), fr[i]}, {s[0], 8'(base + de), fr[j]}, "");
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: out_valid in reset got %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, '0, '0, "");
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R11: out_valid after reset got %b expected 0", out_valid);
      end
    end
    // R1: 1.0 + 1.0 = 2.0
    step(1'b1, {1'b0, 8'd127, 10'd0}, {1'b0, 8'd127, 10'd0}, "R1");
    // R6: 3.0 + (-1.5) = 1.5
    step(1'b1, {1'b0, 8'd128, 10'h200}, {1'b1, 8'd127, 10'h200}, "R6");
    // R3: smaller value on port a, larger negative on b
    step(1'b1, {1'b0, 8'd100, 10'h0F0}, {1'b1, 8'd104, 10'h010}, "");
    // R9: x + (-x)
    step(1'b1, {1'b1, 8'd90, 10'h155}, {1'b0, 8'd90, 10'h155}, "R9");
    // R10: carry out of the top exponent code
    step(1'b1, {1'b0, 8'd255, 10'h3FF}, {1'b0, 8'd255, 10'h3FF}, "R10");
    step(1'b0, '0, '0, "");
    sweep(120);
    sweep(3);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, "");
    checks++;
    if (rd != wr) begin
      errors++;
      $display("FAIL R2: results returned got %0d expected %0d", rd, wr);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2: watchdog expired, got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule